// File: doc/BRIEF.md
# Three-Master Priority Bus Arbiter with Hand-off Locks

This block decides which of three masters owns a shared internal system bus: a processor core, a descriptor-driven transfer engine, and a DMA engine. Each master raises a request, marks the last cycle of each of its bus cycles with an end strobe, and holds a lock flag while it is inside a sequence that must not be split. Ownership follows a fixed priority, with the DMA engine highest, the transfer engine next and the processor last. The bus changes hands only at a legal hand-off point of the current owner.

The processor is the default owner when nothing is requested. A configuration input makes the transfer engine give the bus back to a waiting processor at its next cycle boundary, even though the processor ranks lower. The transfer engine reaches the external bus in two stages. It first wins this arbiter. Only while it holds the internal grant is its request forwarded to the external bus arbiter.

Grants are one-hot and registered. The owner reaches a hand-off point either when its request is low (it is idle) or when its end strobe is high and its lock is low. A new grant appears on the clock edge that samples that point. The choice is made from the requests present at that edge, so a withdrawn request never leads to a grant.

Top module: `bus_owner_arb`

## Requirements
- R1: While reset is held, and right after it is released, the grant is `001` (processor owns the bus) and `ext_req` is 0.
- R2: `gnt` is always one-hot. Bit 0 is the processor, bit 1 is the transfer engine, bit 2 is the DMA engine. The same bit order applies to `m_req`, `m_end` and `m_lock`.
- R3: At a hand-off point, the highest-priority requester is granted on the next edge. The order is DMA (bit 2), then transfer engine (bit 1), then processor (bit 0).
- R4: The grant changes only on the edge that samples a hand-off point of the current owner. A hand-off point is the owner's request low, or the owner's end strobe high with its lock low.
- R5: While the owner requests and holds its lock, the grant does not change, even if its end strobe is high or a higher-priority master requests.
- R6: With `dtc_yield` at 0, the transfer engine keeps the bus across its successive cycle ends while only the processor competes.
- R7: With `dtc_yield` at 1, the transfer engine owning the bus, the processor requesting and the DMA engine idle, the processor is granted on the edge that samples the transfer engine's next hand-off point.
- R8: A master whose request drops before a hand-off point is not granted at that point.
- R9: At a hand-off point with no requests, the grant goes to (or stays with) the processor.
- R10: `ext_req` is 1 exactly when the transfer engine holds the grant, requests, and asks for external space (`dtc_ext`). It is never 1 without that grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dtc_yield | input | 1 | Transfer engine yields to a waiting processor |
| m_req | input | 3 | Bus requests: [2] DMA, [1] transfer engine, [0] processor |
| m_end | input | 3 | Last cycle of the current bus cycle, per master |
| m_lock | input | 3 | Current sequence must not be split, per master |
| dtc_ext | input | 1 | Transfer engine's access targets external space |
| gnt | output | 3 | One-hot registered grant, same bit order |
| ext_req | output | 1 | Request forwarded to the external bus arbiter |

## Verification
A grant decision is due one clock after the inputs that form it. Inputs change on the falling edge, the rising edge registers the grant, and the scoreboard compares 1 ns after that rising edge. `ext_req` depends on the registered grant and on live inputs, so it is due in the same cycle as the grant it follows. It is compared at the same sample point, while the inputs that produced it are still applied. Each stimulus step puts one expected grant/request pair in the queue, and the monitor takes exactly one pair per rising edge.

// File: rtl/bus_owner_arb.sv
module bus_owner_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dtc_yield,
  input  logic [2:0] m_req,
  input  logic [2:0] m_end,
  input  logic [2:0] m_lock,
  input  logic       dtc_ext,
  output logic [2:0] gnt,
  output logic       ext_req
);
  localparam int CPU = 0;
  localparam int DTC = 1;
  localparam int DMA = 2;
  localparam logic [2:0] G_CPU = 3'b001;
  localparam logic [2:0] G_DTC = 3'b010;
  localparam logic [2:0] G_DMA = 3'b100;

  logic [2:0] gnt_q, gnt_d;
  logic       own_req, own_end, own_lock, at_bnd;

  assign own_req  = |(gnt_q & m_req);
  assign own_end  = |(gnt_q & m_end);
  assign own_lock = |(gnt_q & m_lock);
  assign at_bnd   = !own_req || (own_end && !own_lock);

  always_comb begin
    if (m_req[DMA])
      gnt_d = G_DMA;
    else if (m_req[DTC])
      gnt_d = (gnt_q[DTC] && dtc_yield && m_req[CPU]) ? G_CPU : G_DTC;
    else
      gnt_d = G_CPU;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      gnt_q <= G_CPU;
    else if (at_bnd)
      gnt_q <= gnt_d;
  end

  assign gnt     = gnt_q;
  assign ext_req = gnt_q[DTC] && m_req[DTC] && dtc_ext;
endmodule

// File: rtl/bus_owner_arb_chk.sv
module bus_owner_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dtc_yield,
  input logic [2:0] m_req,
  input logic [2:0] m_end,
  input logic [2:0] m_lock,
  input logic       dtc_ext,
  input logic [2:0] gnt,
  input logic       ext_req
);
  logic o_req, o_lock, bnd;
  assign o_req  = |(gnt & m_req);
  assign o_lock = |(gnt & m_lock);
  assign bnd    = !o_req || (|(gnt & m_end) && !o_lock);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1); // R2
  AST_DMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    bnd && m_req[2] |=> gnt == 3'b100); // R3
  AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(gnt)); // R4
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    o_req && o_lock |=> $stable(gnt)); // R5
  AST_YIELD_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    bnd && gnt[1] && dtc_yield && m_req[0] && !m_req[2] |=> gnt[0]); // R7
  AST_NO_STALE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bnd && !m_req[1] |=> !gnt[1]); // R8
  AST_EXT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> gnt[1] && dtc_ext); // R10
endmodule

bind bus_owner_arb bus_owner_arb_chk u_chk (.*);

// File: tb/bus_owner_arb_test.sv
`timescale 1ns/1ps
module bus_owner_arb_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       dtc_yield = 0;
  logic [2:0] m_req = 0, m_end = 0, m_lock = 0;
  logic       dtc_ext = 0;
  logic [2:0] gnt;
  logic       ext_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [2:0] g; logic x; string tag; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  bus_owner_arb uut (.*);

  task automatic step(input logic [2:0] req, input logic [2:0] en, input logic [2:0] lk,
                      input logic y, input logic x, input logic [2:0] eg, input logic ex,
                      input string tag);
    exp_t e;
    @(negedge clk);
    m_req = req; m_end = en; m_lock = lk; dtc_yield = y; dtc_ext = x;
    e.g = eg; e.x = ex; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (gnt !== e.g || ext_req !== e.x) begin
          errors++;
          $display("FAIL %s: gnt=%b ext_req=%b expected gnt=%b ext_req=%b",
                   e.tag, gnt, ext_req, e.g, e.x);
        end
        checks++;
        if ($countones(gnt) != 1) begin
          errors++;
          $display("FAIL R2: gnt=%b expected one-hot", gnt);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gnt !== 3'b001 || ext_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: gnt=%b ext_req=%b expected gnt=001 ext_req=0", gnt, ext_req);
    end
    @(negedge clk); rst_n = 1;
    //    req     end     lock    y  x  gnt     ext
    step(3'b000, 3'b000, 3'b000, 0, 0, 3'b001, 0, "R9 idle stays cpu");
    step(3'b001, 3'b000, 3'b000, 0, 0, 3'b001, 0, "R4 cpu mid cycle");
    step(3'b011, 3'b000, 3'b001, 0, 0, 3'b001, 0, "R5 cpu locked");
    step(3'b011, 3'b001, 3'b001, 0, 0, 3'b001, 0, "R5 end under lock");
    step(3'b011, 3'b001, 3'b000, 0, 0, 3'b010, 0, "R3 dtc over cpu");
    step(3'b011, 3'b010, 3'b000, 0, 0, 3'b010, 0, "R6 dtc keeps bus");
    step(3'b011, 3'b010, 3'b000, 0, 0, 3'b010, 0, "R6 dtc keeps bus again");
    step(3'b111, 3'b000, 3'b000, 0, 0, 3'b010, 0, "R4 dma waits for end");
    step(3'b111, 3'b010, 3'b010, 0, 0, 3'b010, 0, "R5 dtc locked");
    step(3'b111, 3'b010, 3'b000, 0, 0, 3'b100, 0, "R3 dma wins");
    step(3'b111, 3'b000, 3'b000, 0, 0, 3'b100, 0, "R4 dma holds");
    step(3'b011, 3'b000, 3'b000, 0, 0, 3'b010, 0, "R3 dma idle, dtc next");
    step(3'b011, 3'b000, 3'b000, 1, 0, 3'b010, 0, "R7 yield waits for end");
    step(3'b011, 3'b010, 3'b000, 1, 0, 3'b001, 0, "R7 yield to cpu");
    step(3'b011, 3'b000, 3'b000, 0, 1, 3'b001, 0, "R10 no ext without grant");
    step(3'b001, 3'b001, 3'b000, 0, 0, 3'b001, 0, "R8 dtc withdrew");
    step(3'b101, 3'b000, 3'b000, 0, 0, 3'b001, 0, "R8 dma pulse mid cycle");
    step(3'b001, 3'b001, 3'b000, 0, 0, 3'b001, 0, "R8 dma withdrew");
    step(3'b010, 3'b000, 3'b000, 0, 1, 3'b010, 1, "R10 ext after grant");
    step(3'b010, 3'b000, 3'b000, 0, 0, 3'b010, 0, "R10 internal access");
    step(3'b000, 3'b000, 3'b000, 0, 1, 3'b001, 0, "R9 idle returns to cpu");
    step(3'b000, 3'b000, 3'b000, 0, 0, 3'b001, 0, "R9 idle holds cpu");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule